// File: doc/BRIEF.md
# Table-Sequenced Variable-Period PWM Channel

This block drives one pulse-width-modulated output whose switching period can differ from one cycle to the next. The length of each period, counted in clock cycles, comes from a small external lookup memory. A control state machine walks through that memory one entry per period and returns to the first entry after the last. A free-running counter measures out the current period. The output is high while the counter is below a duty compare value, which the channel takes in at each period boundary.

The channel stays idle until `enable` is raised. It then fetches the first entry, loads it and starts counting. Each later entry is fetched one cycle ahead of the rollover, so each period follows the previous one with no gap. The table port is a plain request strobe with a fixed one-cycle read latency. The memory has no way to stall a read, so there is no back-pressure and no valid/ready pair on this port. Dropping `enable` returns the channel to idle at once. The next start begins again at entry 0.

Top module: `pwm_tbl_chan`

## Requirements
- R1: While `rst_n` is low and right after it is released, `pwm_o` and `tbl_rd_o` are 0 and `tbl_addr_o` is 0.
- R2: While `enable` is low, `pwm_o` is 0 in the cycle after, and no table read is issued.
- R3: Each switching period lasts exactly P clock cycles, where P is the table entry loaded at the start of that period.
- R4: Within a period, `pwm_o` is high for the first D cycles and low for the rest, where D is the latched compare value and D < P.
- R5: Entries are used in address order 0, 1, ..., TBL_DEPTH-1, and the sequence then continues again from 0.
- R6: If the latched compare value is at least P, `pwm_o` is high for the whole period. If it is 0, `pwm_o` is low for the whole period.
- R7: `cmp_i` is sampled only at the clock edge that starts a period. A change to `cmp_i` in mid-period does not affect that period.
- R8: The read for the next entry is issued in the second-to-last cycle of the current period: `tbl_rd_o` is 1 for one cycle, and `tbl_addr_o` holds the next entry's address. Table data is taken one cycle after the strobe.
- R9: A table entry of 0 or 1 is treated as a period of 2 cycles.
- R10: Lowering `enable` stops the channel within one cycle. The next start reads address 0 first.
- R11: After `enable` is seen high in idle, the first cycle holds a read of address 0 with `pwm_o` low. The second cycle has `pwm_o` low. The first period starts at the third clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request; low forces idle |
| cmp_i | input | CNT_W | Duty compare value in clock cycles |
| tbl_rd_o | output | 1 | Table read strobe |
| tbl_addr_o | output | ADDR_W | Table read address |
| tbl_data_i | input | CNT_W | Period entry, valid one cycle after the strobe |
| pwm_o | output | 1 | PWM output |

## Verification
The main test plays an uneven period table with a mid-range duty. This shows whether each period has its own length and whether the table wraps after the last entry. Duty values at or above every period, and a duty of zero, test the saturation ends of the compare. A table with 0 and 1 entries tests the period clamp. A compare change in mid-period tells boundary sampling apart from live comparison. Stopping mid-run and then restarting shows whether the address pointer is reset, and the strobe timing is checked in every cycle of every run.

// File: rtl/pwm_tbl_pkg.sv
package pwm_tbl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PRIME = 2'd1,
    ST_FIRST = 2'd2,
    ST_RUN   = 2'd3
  } seq_state_t;

  localparam int MIN_PERIOD = 2;
endpackage

// File: rtl/pwm_tbl_seq.sv
module pwm_tbl_seq
  import pwm_tbl_pkg::*;
#(
  parameter int TBL_DEPTH = 4,
  parameter int ADDR_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              at_pref,
  input  logic              at_wrap,
  output logic              rd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              load_o,
  output logic              run_o
);
  seq_state_t st_q, st_d;
  logic [ADDR_W-1:0] ptr_q, ptr_inc;

  // pointer advance: natural wrap when depth fills the address space
  generate
    if (TBL_DEPTH == (1 << ADDR_W)) begin : g_pow2
      assign ptr_inc = ptr_q + ADDR_W'(1);
    end else begin : g_cmp
      assign ptr_inc = (ptr_q == ADDR_W'(TBL_DEPTH - 1)) ? '0 : ptr_q + ADDR_W'(1);
    end
  endgenerate

  always_comb begin
    st_d = st_q;
    if (!enable) begin
      st_d = ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE:  st_d = ST_PRIME;
        ST_PRIME: st_d = ST_FIRST;
        ST_FIRST: st_d = ST_RUN;
        default:  st_d = ST_RUN;
      endcase
    end
  end

  assign rd_o   = enable && ((st_q == ST_PRIME) || ((st_q == ST_RUN) && at_pref));
  assign load_o = enable && ((st_q == ST_FIRST) || ((st_q == ST_RUN) && at_wrap));
  assign run_o  = (st_q == ST_RUN);
  assign addr_o = ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ptr_q <= '0;
    end else begin
      st_q <= st_d;
      if (!enable)     ptr_q <= '0;
      else if (load_o) ptr_q <= ptr_inc;
    end
  end
endmodule

// File: rtl/pwm_tbl_timebase.sv
module pwm_tbl_timebase
  import pwm_tbl_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             load,
  input  logic             run,
  input  logic [CNT_W-1:0] tbl_data_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] per_o,
  output logic [CNT_W-1:0] duty_o,
  output logic             at_pref,
  output logic             at_wrap
);
  localparam logic [CNT_W-1:0] PMIN = CNT_W'(MIN_PERIOD);

  logic [CNT_W-1:0] cnt_q, per_q, duty_q, per_new;

  assign per_new = (tbl_data_i < PMIN) ? PMIN : tbl_data_i;
  assign at_pref = (cnt_q == per_q - CNT_W'(2));
  assign at_wrap = (cnt_q == per_q - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      per_q  <= PMIN;
      duty_q <= '0;
    end else if (!enable) begin
      cnt_q  <= '0;
      duty_q <= '0;
    end else if (load) begin
      cnt_q  <= '0;
      per_q  <= per_new;
      duty_q <= cmp_i;
    end else if (run) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt_o  = cnt_q;
  assign per_o  = per_q;
  assign duty_o = duty_q;
endmodule

// File: rtl/pwm_tbl_cmp.sv
module pwm_tbl_cmp #(
  parameter int CNT_W = 8
) (
  input  logic             run,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] duty,
  output logic             pwm_o
);
  assign pwm_o = run && (cnt < duty);
endmodule

// File: rtl/pwm_tbl_chan.sv
module pwm_tbl_chan #(
  parameter int CNT_W     = 8,
  parameter int TBL_DEPTH = 4,
  localparam int ADDR_W   = (TBL_DEPTH > 1) ? $clog2(TBL_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [CNT_W-1:0]  cmp_i,
  output logic              tbl_rd_o,
  output logic [ADDR_W-1:0] tbl_addr_o,
  input  logic [CNT_W-1:0]  tbl_data_i,
  output logic              pwm_o
);
  logic             load, run, at_pref, at_wrap;
  logic [CNT_W-1:0] cnt_q, per_q, duty_q;

  pwm_tbl_seq #(.TBL_DEPTH(TBL_DEPTH), .ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .at_pref(at_pref), .at_wrap(at_wrap),
    .rd_o(tbl_rd_o), .addr_o(tbl_addr_o), .load_o(load), .run_o(run)
  );

  pwm_tbl_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .enable(enable), .load(load), .run(run),
    .tbl_data_i(tbl_data_i), .cmp_i(cmp_i),
    .cnt_o(cnt_q), .per_o(per_q), .duty_o(duty_q),
    .at_pref(at_pref), .at_wrap(at_wrap)
  );

  pwm_tbl_cmp #(.CNT_W(CNT_W)) u_cmp (
    .run(run), .cnt(cnt_q), .duty(duty_q), .pwm_o(pwm_o)
  );
endmodule

// File: rtl/pwm_tbl_chan_chk.sv
module pwm_tbl_chan_chk #(
  parameter int CNT_W     = 8,
  parameter int TBL_DEPTH = 4,
  parameter int ADDR_W    = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              tbl_rd_o,
  input logic [ADDR_W-1:0] tbl_addr_o,
  input logic              pwm_o,
  input logic              run,
  input logic              load,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  per_q,
  input logic [CNT_W-1:0]  duty_q
);
  // R3
  cnt_in_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < per_q));

  // R9
  period_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (per_q >= CNT_W'(2)));

  // R8
  single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_rd_o |=> !tbl_rd_o);

  // R2
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!pwm_o && !tbl_rd_o));

  // R5
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_rd_o |-> (tbl_addr_o <= ADDR_W'(TBL_DEPTH - 1)));

  // R7
  duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && run && !load) |=> $stable(duty_q));
endmodule

bind pwm_tbl_chan pwm_tbl_chan_chk #(.CNT_W(CNT_W), .TBL_DEPTH(TBL_DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .tbl_rd_o(tbl_rd_o),
  .tbl_addr_o(tbl_addr_o), .pwm_o(pwm_o), .run(run), .load(load),
  .cnt_q(cnt_q), .per_q(per_q), .duty_q(duty_q)
);

// File: tb/pwm_tbl_chan_tb.sv
module pwm_tbl_chan_tb;
  localparam int CNT_W = 8;
  localparam int DEPTH = 4;
  localparam int AW    = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [CNT_W-1:0] cmp = '0;
  logic tbl_rd;
  logic [AW-1:0] tbl_addr;
  logic [CNT_W-1:0] tbl_data = '0;
  logic pwm;
  logic [CNT_W-1:0] mem [DEPTH];

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  pwm_tbl_chan #(.CNT_W(CNT_W), .TBL_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cmp_i(cmp),
    .tbl_rd_o(tbl_rd), .tbl_addr_o(tbl_addr), .tbl_data_i(tbl_data), .pwm_o(pwm)
  );

  always_ff @(posedge clk) if (tbl_rd) tbl_data <= mem[tbl_addr];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int eff_per(input int v);
    return (v < 2) ? 2 : v;
  endfunction

  // start from idle, check startup (R11), then compare every cycle against a model
  task automatic run_chk(input int ncyc, input int c, input int chg_at, input int c2, input string tag);
    int k, pos, duty, per;
    cmp = CNT_W'(c);
    enable = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(tbl_rd == 1'b1 && tbl_addr == '0 && pwm == 1'b0, "R11 prime", {tbl_rd, tbl_addr, pwm}, 8);
    @(posedge clk); @(negedge clk);
    chk(pwm == 1'b0 && tbl_rd == 1'b0, "R11 first", {tbl_rd, pwm}, 0);
    @(posedge clk);
    k = 0; pos = 0; duty = c;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      per = eff_per(int'(mem[k]));
      chk(pwm == (pos < duty), tag, pwm, int'(pos < duty));
      chk(tbl_rd == (pos == per - 2), "R8 strobe", tbl_rd, int'(pos == per - 2));
      if (tbl_rd) chk(int'(tbl_addr) == (k + 1) % DEPTH, "R5 addr", tbl_addr, (k + 1) % DEPTH);
      if (i == chg_at) cmp = CNT_W'(c2);
      if (pos == per - 1) begin
        pos = 0; k = (k + 1) % DEPTH; duty = int'(cmp);
      end else pos++;
    end
  endtask

  task automatic stop_chk(input string tag);
    enable = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(pwm == 1'b0 && tbl_rd == 1'b0 && tbl_addr == '0, tag, {pwm, tbl_rd, tbl_addr}, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(pwm == 1'b0 && tbl_rd == 1'b0 && tbl_addr == '0, "R1 in reset", {pwm, tbl_rd, tbl_addr}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pwm == 1'b0 && tbl_rd == 1'b0 && tbl_addr == '0, "R1 after reset", {pwm, tbl_rd, tbl_addr}, 0);
  endtask

  task automatic t_idle();
    cmp = 8'd9;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(pwm == 1'b0 && tbl_rd == 1'b0, "R2 idle", {pwm, tbl_rd}, 0);
    end
  endtask

  task automatic t_seq();
    mem[0] = 8'd5; mem[1] = 8'd3; mem[2] = 8'd7; mem[3] = 8'd4;
    run_chk(2 * 19 + 3, 2, -1, 0, "R3/R4 uneven table");
    stop_chk("R10 stop");
    mem[0] = 8'd6; mem[1] = 8'd2; mem[2] = 8'd9; mem[3] = 8'd3;
    run_chk(40, 3, -1, 0, "R3/R4/R5 second table");
    stop_chk("R10 stop");
  endtask

  task automatic t_sat();
    mem[0] = 8'd5; mem[1] = 8'd3; mem[2] = 8'd7; mem[3] = 8'd4;
    run_chk(30, 200, -1, 0, "R6 full high");
    stop_chk("R10 stop");
    run_chk(30, 0, -1, 0, "R6 zero low");
    stop_chk("R10 stop");
    run_chk(30, 5, -1, 0, "R6 duty equals some periods");
    stop_chk("R10 stop");
  endtask

  task automatic t_sample();
    mem[0] = 8'd8; mem[1] = 8'd8; mem[2] = 8'd8; mem[3] = 8'd8;
    run_chk(32, 2, 3, 6, "R7 mid-period change");
    stop_chk("R10 stop");
  endtask

  task automatic t_clamp();
    mem[0] = 8'd0; mem[1] = 8'd1; mem[2] = 8'd2; mem[3] = 8'd1;
    run_chk(24, 1, -1, 0, "R9 clamp");
    stop_chk("R10 stop");
  endtask

  task automatic t_restart();
    mem[0] = 8'd5; mem[1] = 8'd3; mem[2] = 8'd7; mem[3] = 8'd4;
    run_chk(10, 2, -1, 0, "R10 partial run");
    stop_chk("R10 stop mid-run");
    repeat (3) begin
      @(negedge clk);
      chk(pwm == 1'b0 && tbl_rd == 1'b0, "R2 idle after stop", {pwm, tbl_rd}, 0);
    end
    run_chk(25, 2, -1, 0, "R10 restart from entry 0");
    stop_chk("R10 stop");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'd4;
    @(negedge clk);
    t_reset();
    t_idle();
    t_seq();
    t_sat();
    t_sample();
    t_clamp();
    t_restart();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule